// File: doc/BRIEF.md
# Line Modem Activation Sequencer

This block steers one end of a point-to-point line modem from idle to full data transfer. A static role input makes it the end that starts the attempt (master) or the end that answers (slave). After a request it walks through a fixed chain of training sub-states. An internal activation timer and a set of programmable timer marks decide when each step ends. In each sub-state it picks the transmit symbol class and raises training strobes for the automatic gain control, echo canceller, clock recovery loop and equalizer.

The master keeps sending the two-level symbol from the start. It presets its gain and echo paths against its own signal and then listens for the slave. When the slave is first heard, the master reloads its timer to one past the second mark, so both ends run the rest of the chain in step. The slave stays silent while its gain settles. It then answers and trains its echo path, and runs its clock recovery in a frequency step followed by a phase step. Both ends then train the equalizer, switch to the four-level symbol and wait to hear it back. In the framed modes they also wait for two good frame-sync words in a row before going fully active.

The timer marks, the skew offset and the abort limit are static inputs. The block checks that they are strictly ordered. A missing far-end response, a dropped request or loss of signal while active sends it back to idle.

Top module: `lnk_act_seq`

## Requirements
- R1: After reset, state_o is 0 (idle), tx_sym_o is 0 (silent), all four training strobes are low and active_o is low.
- R2: cfg_ok_o is high only when mark1 < mark2 < mark3 < mark4 < mark5 and mark5 + skew < limit. While it is low, the block stays in idle whatever the request.
- R3: A master (role_slave_i = 0) with act_req_i high leaves idle for state 1 (gain preset) with the timer at 0. The timer counts up once per cycle. The block moves to state 2 (echo preset) at the edge where the timer equals mark1, and to state 3 (listen) at the edge where the timer first exceeds mark2.
- R4: In state 3, the master moves to state 5 (echo training) when s0_det_i is high and loads its timer with mark2 + 1.
- R5: A slave (role_slave_i = 1) leaves idle only when act_req_i and s0_det_i are both high. It enters state 4 (silent wait, gain strobe) with the timer at 0, and moves to state 5 at the edge where the timer first exceeds mark2.
- R6: On the master, states 5, 7 (clock phase) and 8 (equalizer) end when the timer reaches mark3 + skew, mark4 + skew and mark5 + skew. On the slave, state 5 ends at mark3, then state 6 (clock frequency) at mark4, state 7 at mark5 and state 8 at mark5 + skew.
- R7: In state 9 (four-level detect) the block sends the four-level symbol and leaves when s1_det_i is high.
- R8: For mode_sel_i of 6 or 7, state 9 leads to state 10 (frame detect). State 10 goes on to state 11 once two good sync words arrive in a row: a fsw_stb_i pulse with fsw_ok_i high counts one, and a pulse with fsw_ok_i low restarts the count. For modes 0 to 5, state 9 goes straight to state 11.
- R9: In state 11 (active), tx_sym_o is 3 (data) and active_o equals the inverse of los_i. A high los_i returns the block to idle at the next edge.
- R10: In states 3, 9 and 10, if the awaited event has not come and the timer has reached limit, the block returns to idle.
- R11: A low act_req_i in any non-idle state returns the block to idle at the next edge.
- R12: tx_sym_o encodes 0 silent, 1 two-level, 2 four-level, 3 data. Per state {tx, agc, ec, pll, eq}: 0 {0,0000}, 1 {1,1000}, 2 {1,0100}, 3 {1,0000}, 4 {0,1000}, 5 {1,1100}, 6 {1,0010}, 7 {1,0010}, 8 {1,0001}, 9 {2,0000}, 10 {2,0000}, 11 {3,0000}.
- R13: State changes only follow the chain: idle to 1 or 4, 1 to 2, 2 to 3, 3 to 5, 4 to 5, 5 to 6 or 7, 6 to 7, 7 to 8, 8 to 9, 9 to 10 or 11, 10 to 11, and any state back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_slave_i | input | 1 | Static role: 0 master, 1 slave |
| act_req_i | input | 1 | Activation request, held for the whole attempt |
| s0_det_i | input | 1 | Far-end two-level signal detected |
| s1_det_i | input | 1 | Far-end four-level signal detected |
| fsw_stb_i | input | 1 | One-cycle strobe per received sync word |
| fsw_ok_i | input | 1 | Sync word at the strobe was good |
| mode_sel_i | input | 3 | Line mode; 6 and 7 are framed |
| los_i | input | 1 | Loss of signal |
| mark1_i | input | TW | End of master gain preset |
| mark2_i | input | TW | End of silent wait / echo preset; resync base |
| mark3_i | input | TW | End of echo training |
| mark4_i | input | TW | End of clock frequency / master phase training |
| mark5_i | input | TW | End of slave phase / equalizer base |
| skew_i | input | TW | Offset added to the master end points |
| limit_i | input | TW | Abort limit for the waiting states |
| state_o | output | 4 | Current state code (R12) |
| tx_sym_o | output | 2 | Transmit symbol class |
| agc_en_o | output | 1 | Gain training strobe |
| ec_en_o | output | 1 | Echo canceller training strobe |
| pll_en_o | output | 1 | Clock recovery training strobe |
| eq_en_o | output | 1 | Equalizer training strobe |
| active_o | output | 1 | Fully active |
| cfg_ok_o | output | 1 | Timer marks are ordered |

## Verification
The chain runs as a master that hears the slave late, as a slave in a framed mode, and as a master whose far end never answers. These three runs separate the skewed master end points from the plain slave ones, the resync load from free counting, and the response path from the timeout path. The frame run mixes a bad sync word and an idle gap between good ones, which shows that only back-to-back good words count. A marks set that is out of order, a limit on the boundary, a dropped request and loss of signal while active each test one way back to idle or one refusal to leave it.

// File: rtl/lnk_act_pkg.sv
`timescale 1ns/1ps
package lnk_act_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_M_PREAGC  = 4'd1,
        ST_M_PREEC   = 4'd2,
        ST_M_LISTEN  = 4'd3,
        ST_S_WAIT    = 4'd4,
        ST_EC        = 4'd5,
        ST_PLL_FREQ  = 4'd6,
        ST_PLL_PHASE = 4'd7,
        ST_EQ        = 4'd8,
        ST_S1_DET    = 4'd9,
        ST_FRM_DET   = 4'd10,
        ST_ACTIVE    = 4'd11
    } act_state_e;

    typedef enum logic [1:0] {
        TX_SILENT = 2'd0,
        TX_S0     = 2'd1,
        TX_S1     = 2'd2,
        TX_DATA   = 2'd3
    } tx_sym_e;

    typedef struct packed {
        logic agc;
        logic ec;
        logic pll;
        logic eq;
    } train_en_t;

    localparam int FRAMED_FIRST_MODE = 6;
    localparam int N_MARKS = 5;

    function automatic logic mode_is_framed(input logic [2:0] mode);
        return int'(mode) >= FRAMED_FIRST_MODE;
    endfunction

    function automatic logic state_waits_far(input act_state_e s);
        return (s == ST_M_LISTEN) || (s == ST_S1_DET) || (s == ST_FRM_DET);
    endfunction

endpackage

// File: rtl/lnk_act_timer.sv
`timescale 1ns/1ps
module lnk_act_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic [TW-1:0] cnt_o
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + TW'(1);
    end

    assign cnt_o = cnt_q;

    p_resync_load_r4: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clr_i) |=> (cnt_q == $past(load_val_i)));

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !load_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + TW'(1)));

endmodule

// File: rtl/lnk_act_cfg_chk.sv
`timescale 1ns/1ps
module lnk_act_cfg_chk
    import lnk_act_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [TW-1:0] mark_i [N_MARKS],
    input  logic [TW-1:0] skew_i,
    input  logic [TW-1:0] limit_i,
    output logic          ok_o
);
    localparam int NPAIR = N_MARKS - 1;

    logic [NPAIR-1:0] pair_ok;
    logic [TW:0]      last_end;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair_ok[g] = mark_i[g] < mark_i[g+1];
    end

    assign last_end = {1'b0, mark_i[N_MARKS-1]} + {1'b0, skew_i};
    assign ok_o     = (&pair_ok) && (last_end < {1'b0, limit_i});

endmodule

// File: rtl/lnk_act_fsm.sv
`timescale 1ns/1ps
module lnk_act_fsm
    import lnk_act_pkg::*;
#(
    parameter int TW       = 16,
    parameter int FSW_NEED = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          role_slave_i,
    input  logic          act_req_i,
    input  logic          s0_det_i,
    input  logic          s1_det_i,
    input  logic          fsw_stb_i,
    input  logic          fsw_ok_i,
    input  logic          framed_i,
    input  logic          los_i,
    input  logic          cfg_ok_i,
    input  logic [TW-1:0] tmr_i,
    input  logic [TW-1:0] mark_i [N_MARKS],
    input  logic [TW-1:0] skew_i,
    input  logic [TW-1:0] limit_i,
    output act_state_e    state_o,
    output logic          tmr_clr_o,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_load_val_o
);
    localparam int FW = $clog2(FSW_NEED + 1);
    localparam logic [FW:0] NEED_V = (FW+1)'(FSW_NEED);

    act_state_e st_q, st_d;
    logic [FW-1:0] fsw_cnt_q, fsw_cnt_d;
    logic [FW:0]   fsw_inc;
    logic [TW:0]   tmr_x, end_ec, end_pll, end_eq, skew_m;
    logic          time_out;

    assign tmr_x    = {1'b0, tmr_i};
    assign skew_m   = role_slave_i ? '0 : {1'b0, skew_i};
    assign end_ec   = {1'b0, mark_i[2]} + skew_m;
    assign end_pll  = role_slave_i ? {1'b0, mark_i[4]} : ({1'b0, mark_i[3]} + skew_m);
    assign end_eq   = {1'b0, mark_i[4]} + {1'b0, skew_i};
    assign time_out = tmr_x >= {1'b0, limit_i};
    assign fsw_inc  = {1'b0, fsw_cnt_q} + (FW+1)'(1);

    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        fsw_cnt_d  = '0;
        if (st_q != ST_IDLE && !act_req_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (act_req_i && cfg_ok_i) begin
                        if (!role_slave_i)  st_d = ST_M_PREAGC;
                        else if (s0_det_i)  st_d = ST_S_WAIT;
                    end
                end
                ST_M_PREAGC:
                    if (tmr_x >= {1'b0, mark_i[0]}) st_d = ST_M_PREEC;
                ST_M_PREEC:
                    if (tmr_x > {1'b0, mark_i[1]}) st_d = ST_M_LISTEN;
                ST_M_LISTEN: begin
                    if (s0_det_i) begin
                        st_d       = ST_EC;
                        tmr_load_o = 1'b1;
                    end else if (time_out) begin
                        st_d = ST_IDLE;
                    end
                end
                ST_S_WAIT:
                    if (tmr_x > {1'b0, mark_i[1]}) st_d = ST_EC;
                ST_EC:
                    if (tmr_x >= end_ec) st_d = role_slave_i ? ST_PLL_FREQ : ST_PLL_PHASE;
                ST_PLL_FREQ:
                    if (tmr_x >= {1'b0, mark_i[3]}) st_d = ST_PLL_PHASE;
                ST_PLL_PHASE:
                    if (tmr_x >= end_pll) st_d = ST_EQ;
                ST_EQ:
                    if (tmr_x >= end_eq) st_d = ST_S1_DET;
                ST_S1_DET: begin
                    if (s1_det_i)      st_d = framed_i ? ST_FRM_DET : ST_ACTIVE;
                    else if (time_out) st_d = ST_IDLE;
                end
                ST_FRM_DET: begin
                    fsw_cnt_d = fsw_cnt_q;
                    if (fsw_stb_i) begin
                        if (!fsw_ok_i)              fsw_cnt_d = '0;
                        else if (fsw_inc >= NEED_V) st_d = ST_ACTIVE;
                        else                        fsw_cnt_d = fsw_inc[FW-1:0];
                    end else if (time_out) begin
                        st_d = ST_IDLE;
                    end
                end
                ST_ACTIVE:
                    if (los_i) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            fsw_cnt_q <= '0;
        end else begin
            st_q      <= st_d;
            fsw_cnt_q <= fsw_cnt_d;
        end
    end

    assign state_o        = st_q;
    assign tmr_clr_o      = (st_q == ST_IDLE);
    assign tmr_load_val_o = mark_i[1] + TW'(1);

    p_idle_exit_r13: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_M_PREAGC || st_q == ST_S_WAIT));

    p_drop_req_r11: assert property (@(posedge clk) disable iff (rst)
        (!act_req_i) |=> (st_q == ST_IDLE));

    p_resync_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_M_LISTEN && act_req_i && s0_det_i) |=> (st_q == ST_EC && tmr_i == $past(mark_i[1]) + TW'(1)));

    p_cfg_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !cfg_ok_i) |=> (st_q == ST_IDLE));

    p_los_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACTIVE && los_i) |=> (st_q == ST_IDLE));

    p_slave_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && role_slave_i && !s0_det_i) |=> (st_q == ST_IDLE));

    p_timeout_r10: assert property (@(posedge clk) disable iff (rst)
        (state_waits_far(st_q) && time_out && !s0_det_i && !s1_det_i && !fsw_stb_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/lnk_act_out_dec.sv
`timescale 1ns/1ps
module lnk_act_out_dec
    import lnk_act_pkg::*;
(
    input  act_state_e state_i,
    input  logic       los_i,
    output tx_sym_e    tx_o,
    output train_en_t  en_o,
    output logic       active_o
);
    always_comb begin
        tx_o     = TX_SILENT;
        en_o     = '0;
        active_o = 1'b0;
        unique case (state_i)
            ST_IDLE:      tx_o = TX_SILENT;
            ST_M_PREAGC:  begin tx_o = TX_S0; en_o.agc = 1'b1; end
            ST_M_PREEC:   begin tx_o = TX_S0; en_o.ec  = 1'b1; end
            ST_M_LISTEN:  tx_o = TX_S0;
            ST_S_WAIT:    en_o.agc = 1'b1;
            ST_EC:        begin tx_o = TX_S0; en_o.ec = 1'b1; en_o.agc = 1'b1; end
            ST_PLL_FREQ,
            ST_PLL_PHASE: begin tx_o = TX_S0; en_o.pll = 1'b1; end
            ST_EQ:        begin tx_o = TX_S0; en_o.eq  = 1'b1; end
            ST_S1_DET,
            ST_FRM_DET:   tx_o = TX_S1;
            ST_ACTIVE:    begin tx_o = TX_DATA; active_o = !los_i; end
            default:      tx_o = TX_SILENT;
        endcase
    end
endmodule

// File: rtl/lnk_act_seq.sv
`timescale 1ns/1ps
module lnk_act_seq
    import lnk_act_pkg::*;
#(
    parameter int TW       = 16,
    parameter int FSW_NEED = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          role_slave_i,
    input  logic          act_req_i,
    input  logic          s0_det_i,
    input  logic          s1_det_i,
    input  logic          fsw_stb_i,
    input  logic          fsw_ok_i,
    input  logic [2:0]    mode_sel_i,
    input  logic          los_i,
    input  logic [TW-1:0] mark1_i,
    input  logic [TW-1:0] mark2_i,
    input  logic [TW-1:0] mark3_i,
    input  logic [TW-1:0] mark4_i,
    input  logic [TW-1:0] mark5_i,
    input  logic [TW-1:0] skew_i,
    input  logic [TW-1:0] limit_i,
    output logic [3:0]    state_o,
    output logic [1:0]    tx_sym_o,
    output logic          agc_en_o,
    output logic          ec_en_o,
    output logic          pll_en_o,
    output logic          eq_en_o,
    output logic          active_o,
    output logic          cfg_ok_o
);
    logic [TW-1:0] marks [N_MARKS];
    logic [TW-1:0] tmr, tmr_load_val;
    logic          tmr_clr, tmr_load, cfg_ok;
    act_state_e    st;
    tx_sym_e       tx;
    train_en_t     en;

    assign marks[0] = mark1_i;
    assign marks[1] = mark2_i;
    assign marks[2] = mark3_i;
    assign marks[3] = mark4_i;
    assign marks[4] = mark5_i;

    lnk_act_cfg_chk #(.TW(TW)) u_cfg (
        .mark_i  (marks),
        .skew_i  (skew_i),
        .limit_i (limit_i),
        .ok_o    (cfg_ok)
    );

    lnk_act_timer #(.TW(TW)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (tmr_clr),
        .load_i     (tmr_load),
        .load_val_i (tmr_load_val),
        .cnt_o      (tmr)
    );

    lnk_act_fsm #(.TW(TW), .FSW_NEED(FSW_NEED)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .role_slave_i   (role_slave_i),
        .act_req_i      (act_req_i),
        .s0_det_i       (s0_det_i),
        .s1_det_i       (s1_det_i),
        .fsw_stb_i      (fsw_stb_i),
        .fsw_ok_i       (fsw_ok_i),
        .framed_i       (mode_is_framed(mode_sel_i)),
        .los_i          (los_i),
        .cfg_ok_i       (cfg_ok),
        .tmr_i          (tmr),
        .mark_i         (marks),
        .skew_i         (skew_i),
        .limit_i        (limit_i),
        .state_o        (st),
        .tmr_clr_o      (tmr_clr),
        .tmr_load_o     (tmr_load),
        .tmr_load_val_o (tmr_load_val)
    );

    lnk_act_out_dec u_dec (
        .state_i  (st),
        .los_i    (los_i),
        .tx_o     (tx),
        .en_o     (en),
        .active_o (active_o)
    );

    assign state_o  = st;
    assign tx_sym_o = tx;
    assign agc_en_o = en.agc;
    assign ec_en_o  = en.ec;
    assign pll_en_o = en.pll;
    assign eq_en_o  = en.eq;
    assign cfg_ok_o = cfg_ok;

    p_wait_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S_WAIT) |-> (tx_sym_o == 2'd0 && agc_en_o && !ec_en_o));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (tx_sym_o == 2'd0 && !agc_en_o && !ec_en_o && !pll_en_o && !eq_en_o && !active_o));

endmodule

// File: tb/sim_lnk_act_seq.sv
`timescale 1ns/1ps
module sim_lnk_act_seq;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_slave = 1'b0, act_req = 1'b0, s0_det = 1'b0, s1_det = 1'b0;
    logic fsw_stb = 1'b0, fsw_ok = 1'b0, los = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic [TW-1:0] m1 = 16'd3, m2 = 16'd6, m3 = 16'd10, m4 = 16'd14, m5 = 16'd18;
    logic [TW-1:0] skew = 16'd2, limit = 16'd40;
    logic [3:0] state;
    logic [1:0] tx_sym;
    logic agc_en, ec_en, pll_en, eq_en, active, cfg_ok;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] prev_state = 4'd0;

    always #2.5 clk = ~clk;

    lnk_act_seq #(.TW(TW), .FSW_NEED(2)) u0 (
        .clk(clk), .rst(rst), .role_slave_i(role_slave), .act_req_i(act_req),
        .s0_det_i(s0_det), .s1_det_i(s1_det), .fsw_stb_i(fsw_stb), .fsw_ok_i(fsw_ok),
        .mode_sel_i(mode_sel), .los_i(los),
        .mark1_i(m1), .mark2_i(m2), .mark3_i(m3), .mark4_i(m4), .mark5_i(m5),
        .skew_i(skew), .limit_i(limit),
        .state_o(state), .tx_sym_o(tx_sym), .agc_en_o(agc_en), .ec_en_o(ec_en),
        .pll_en_o(pll_en), .eq_en_o(eq_en), .active_o(active), .cfg_ok_o(cfg_ok)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R12 table: {tx[1:0], agc, ec, pll, eq}
    function automatic int exp_out(input int code);
        case (code)
            1: return 6'b01_1000;
            2: return 6'b01_0100;
            3: return 6'b01_0000;
            4: return 6'b00_1000;
            5: return 6'b01_1100;
            6: return 6'b01_0010;
            7: return 6'b01_0010;
            8: return 6'b01_0001;
            9: return 6'b10_0000;
            10: return 6'b10_0000;
            11: return 6'b11_0000;
            default: return 6'b00_0000;
        endcase
    endfunction

    task automatic hold_state(input int code, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check(state, code, tag);
            check({tx_sym, agc_en, ec_en, pll_en, eq_en}, exp_out(code), "R12 outputs per state");
            step();
        end
    endtask

    // R13: legal transitions only
    function automatic logic legal_move(input int a, input int b);
        if (b == 0) return 1'b1;
        case (a)
            0: return b == 1 || b == 4;
            1: return b == 2;
            2: return b == 3;
            3: return b == 5;
            4: return b == 5;
            5: return b == 6 || b == 7;
            6: return b == 7;
            7: return b == 8;
            8: return b == 9;
            9: return b == 10 || b == 11;
            10: return b == 11;
            default: return 1'b0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && state != prev_state)
            check(int'(legal_move(int'(prev_state), int'(state))), 1, "R13 state order");
        prev_state <= state;
    end

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic t_reset();
        check(state, 0, "R1 idle state");
        check(tx_sym, 0, "R1 tx silent");
        check({agc_en, ec_en, pll_en, eq_en}, 0, "R1 strobes low");
        check(active, 0, "R1 active low");
        check(cfg_ok, 1, "R2 ordered marks accepted");
    endtask

    task automatic t_cfg_gate();
        m3 = 16'd6; #1;
        check(cfg_ok, 0, "R2 mark3 equal mark2 rejected");
        act_req = 1'b1;
        hold_state(0, 5, "R2 stays idle on bad marks");
        act_req = 1'b0;
        m3 = 16'd10; limit = 16'd20; #1;
        check(cfg_ok, 0, "R2 limit equal to mark5+skew rejected");
        limit = 16'd21; #1;
        check(cfg_ok, 1, "R2 limit one above accepted");
        limit = 16'd40; #1;
        step();
    endtask

    task automatic t_master_unframed();
        role_slave = 1'b0; mode_sel = 3'd0; act_req = 1'b1;
        step();
        hold_state(1, 4, "R3 gain preset until mark1");
        hold_state(2, 4, "R3 echo preset until past mark2");
        hold_state(3, 5, "R4 listen waits for slave");
        s0_det = 1'b1;
        step();
        s0_det = 1'b0;
        hold_state(5, 6, "R4 R6 echo from resync to mark3+skew");
        hold_state(7, 4, "R6 master phase until mark4+skew");
        hold_state(8, 4, "R6 equalizer until mark5+skew");
        hold_state(9, 3, "R7 four-level wait");
        s1_det = 1'b1;
        step();
        s1_det = 1'b0;
        check(state, 11, "R8 unframed mode skips frame detect");
        check(tx_sym, 3, "R9 data symbol");
        check(active, 1, "R9 active with signal");
        los = 1'b1; #1;
        check(active, 0, "R9 active drops with los");
        step();
        check(state, 0, "R9 los returns to idle");
        los = 1'b0; act_req = 1'b0;
        step();
        check(state, 0, "R11 idle with request low");
    endtask

    task automatic t_slave_framed();
        role_slave = 1'b1; mode_sel = 3'd6; act_req = 1'b1;
        hold_state(0, 3, "R5 slave waits for far signal");
        s0_det = 1'b1;
        step();
        hold_state(4, 8, "R5 silent wait until past mark2");
        hold_state(5, 3, "R6 slave echo until mark3");
        hold_state(6, 4, "R6 slave frequency until mark4");
        hold_state(7, 4, "R6 slave phase until mark5");
        hold_state(8, 2, "R6 slave equalizer until mark5+skew");
        hold_state(9, 2, "R7 four-level wait");
        s1_det = 1'b1;
        step();
        s1_det = 1'b0;
        check(state, 10, "R8 framed mode enters frame detect");
        fsw_stb = 1'b1; fsw_ok = 1'b1;
        step();
        check(state, 10, "R8 one good word not enough");
        fsw_ok = 1'b0;
        step();
        check(state, 10, "R8 bad word restarts count");
        fsw_ok = 1'b1;
        step();
        fsw_stb = 1'b0;
        check(state, 10, "R8 first good after restart");
        step();
        check(state, 10, "R8 gap keeps count");
        fsw_stb = 1'b1;
        step();
        fsw_stb = 1'b0; fsw_ok = 1'b0;
        check(state, 11, "R8 two good words give active");
        check(active, 1, "R9 active slave");
        act_req = 1'b0; s0_det = 1'b0;
        step();
        check(state, 0, "R11 request drop from active");
    endtask

    task automatic t_timeout();
        role_slave = 1'b0; mode_sel = 3'd0; act_req = 1'b1;
        step();
        hold_state(1, 4, "R3 gain preset");
        hold_state(2, 4, "R3 echo preset");
        hold_state(3, 33, "R10 listen until limit");
        check(state, 0, "R10 timeout returns to idle");
        act_req = 1'b0;
        step();
    endtask

    task automatic t_abort();
        role_slave = 1'b0; act_req = 1'b1;
        step();
        hold_state(1, 4, "R3 gain preset");
        hold_state(2, 2, "R3 echo preset");
        act_req = 1'b0;
        step();
        check(state, 0, "R11 abort mid training");
        check(tx_sym, 0, "R11 silent after abort");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        step(); step(); step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_cfg_gate();
        t_master_unframed();
        t_slave_framed();
        t_timeout();
        t_abort();
        step();
        finish_run();
    end
endmodule